// File: doc/BRIEF.md
# Paired Message Queue Pool

This block is a pool of message queues for carrying frame pointers between a local processor and remote bus masters. Each logical queue has a direction and is built from two hardware FIFOs: a posted list and a free list. A producer takes an empty frame pointer from the free list, fills the frame, and writes the pointer to the posted list. The consumer pops the posted list, handles the frame, and returns the pointer to the free list. Every list appears as a single register on each of two register buses, one for the local side and one for the remote side. A write to the register appends an entry. A read returns the oldest entry and removes it in the same access.

Each bus access completes in the cycle it is presented. Read data is combinational from the selected list. The pop, or any other state change, takes effect at the closing clock edge. The local bus is never stalled. When the two sides touch the same queue, or both touch the control space, the remote bus waits. Queue depth is set at run time by the local side, up to a fixed maximum. A sticky status word records pushes that were dropped because the list was full.

Top module: `msgq_pool`

## Requirements
- R1: A write to a queue port address `{0, q, list}` that the writing side may push appends the word at the tail of that list. Reads return words in the order they were written. The list bit is 0 for the posted list and 1 for the free list.
- R2: A permitted read of a queue port returns the head word and removes it in the same access, so the next read returns the following word.
- R3: A permitted read of an empty list returns 32'hFFFF_FFFF and leaves the list unchanged.
- R4: A push to a full list is dropped and sets sticky status bit `2*q+list`. The status word is read at address `{1, any q, 1}`. Writing ones to that address clears the matching bits.
- R5: Queues 0..NUM_IN-1 are inbound: the remote side pushes their posted list and pops their free list, and the local side does the reverse. The remaining queues are outbound, with the roles of the two sides swapped. A read from the side that may not pop returns all-ones and removes nothing. A write from the side that may not push is discarded and sets no status bit.
- R6: A local write to `{1, q, 0}` sets queue q's depth from `wdata[PW:0]` and empties both of its lists. A value of 0 or above MAX_DEPTH selects MAX_DEPTH. Either side can read the depth back at that address. A remote write there has no effect.
- R7: After reset every list is empty, every depth is MAX_DEPTH, the status word is zero and no not-empty output is high.
- R8: `lcl_ne[2*q+list]` is high exactly when that list holds data and the local side pops it. `rmt_ne` does the same for the remote side.
- R9: When both buses are valid in the same cycle and either address the same queue index or both address the control space, `rmt_rdy` is low and only the local access takes effect. The remote access completes in a later cycle.
- R10: The two lists of a queue are independent: pushing and popping one never changes the contents of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lcl_vld | input | 1 | Local access valid |
| lcl_we | input | 1 | Local access is a write |
| lcl_addr | input | BA | Local register address |
| lcl_wdata | input | DW | Local write data |
| lcl_rdata | output | DW | Local read data, valid while lcl_vld |
| rmt_vld | input | 1 | Remote access valid |
| rmt_we | input | 1 | Remote access is a write |
| rmt_addr | input | BA | Remote register address |
| rmt_wdata | input | DW | Remote write data |
| rmt_rdata | output | DW | Remote read data, valid while rmt_vld and rmt_rdy |
| rmt_rdy | output | 1 | Remote access accepted this cycle |
| lcl_ne | output | NF | Not-empty flags for lists the local side pops |
| rmt_ne | output | NF | Not-empty flags for lists the remote side pops |

## Verification
The bench builds the pool with two inbound queues, two outbound queues, 32-bit entries and a MAX_DEPTH of 4. With a depth of 4, five pushes are enough to reach the full-list drop and its status bit. Reallocating a queue to a depth of 2 exercises a run-time depth that is smaller than the storage. With this setup the inbound and outbound side rules can be checked on real queue indices, and a same-queue collision between the two buses is reached within a few cycles.

// File: rtl/msgq_pkg.sv
// Package: shared encodings for the paired message queue pool.
// Assumes list bit 0 selects the posted list and 1 selects the free list.
package msgq_pkg;

    typedef enum logic {
        LIST_POST = 1'b0,
        LIST_FREE = 1'b1
    } msgq_list_e;

    // True when the local side is the one that pushes list `lst` of queue `q`.
    function automatic bit local_pushes(input int q, input int nin, input bit lst);
        bit inbound;
        inbound = (q < nin);
        return inbound ? (lst == bit'(LIST_FREE)) : (lst == bit'(LIST_POST));
    endfunction

endpackage

// File: rtl/msgq_fifo.sv
// Module: one pointer FIFO with a run-time depth limit.
// Assumes DEPTH is a power of two and at most one of push/pop per cycle
// (the pool serialises sides); flush empties the list.
module msgq_fifo #(
    parameter int DW    = 32,
    parameter int DEPTH = 4,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = PW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic          flush,
    input  logic [DW-1:0] wdata,
    input  logic [CW-1:0] limit,
    output logic [DW-1:0] head,
    output logic          empty,
    output logic          drop
);
    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          full, do_push, do_pop;

    // Status and accepted operations for this cycle.
    always_comb begin
        empty   = (cnt == '0);
        full    = (cnt >= limit);
        do_push = push && !full;
        do_pop  = pop && !empty;
        drop    = push && full && !flush;
        head    = mem[rp];
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= wp + 1'b1;
            if (do_pop)  rp <= rp + 1'b1;
            cnt <= cnt + CW'(do_push) - CW'(do_pop);
        end
    end

    // Entry storage write.
    always_ff @(posedge clk) begin
        if (do_push && !flush) mem[wp] <= wdata;
    end

    a_r4_cnt_within_depth: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= limit);
    a_r3_empty_pop_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push && !flush) |=> (cnt == '0));
    a_r4_full_push_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !flush) |=> $stable(cnt));
    a_r2_pop_advances: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !empty && !push && !flush) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/msgq_side.sv
// Module: address decode and access rules for one bus side.
// Assumes address = {ctrl, q, lst}; go is the accepted access strobe.
module msgq_side #(
    parameter int NQ       = 4,
    parameter int NIN      = 2,
    parameter int DW       = 32,
    parameter int CW       = 3,
    parameter bit IS_LOCAL = 1'b1,
    localparam int NF      = 2 * NQ,
    localparam int QW      = $clog2(NQ),
    localparam int BA      = QW + 2
) (
    input  logic                   go,
    input  logic                   we,
    input  logic [BA-1:0]          addr,
    input  logic [DW-1:0]          wdata,
    input  logic [NF-1:0][DW-1:0]  heads,
    input  logic [NF-1:0]          empties,
    input  logic [NQ-1:0][CW-1:0]  depths,
    input  logic [NF-1:0]          ovf,
    output logic [NF-1:0]          push,
    output logic [NF-1:0]          pop,
    output logic [NF-1:0]          pop_ok,
    output logic [NF-1:0]          stat_clr,
    output logic                   alloc_we,
    output logic [QW-1:0]          alloc_q,
    output logic [DW-1:0]          rdata
);
    import msgq_pkg::*;

    logic [NF-1:0] push_ok;
    logic          is_ctrl;
    logic [BA-2:0] fsel;

    // Fixed per-list permission for this side.
    for (genvar f = 0; f < NF; f++) begin : g_perm
        localparam bit LP = local_pushes(f / 2, NIN, bit'(f % 2));
        assign push_ok[f] = (IS_LOCAL == LP);
        assign pop_ok[f]  = (IS_LOCAL != LP);
    end

    // Field split and per-list strobes.
    always_comb begin
        is_ctrl  = addr[BA-1];
        fsel     = addr[BA-2:0];
        alloc_q  = addr[BA-2:1];
        push     = '0;
        pop      = '0;
        if (go && !is_ctrl) begin
            push[fsel] = we && push_ok[fsel];
            pop[fsel]  = !we && pop_ok[fsel] && !empties[fsel];
        end
        alloc_we = go && we && is_ctrl && !addr[0] && IS_LOCAL;
        stat_clr = (go && we && is_ctrl && addr[0]) ? wdata[NF-1:0] : '0;
    end

    // Read mux: head, sentinel, status or depth.
    always_comb begin
        if (!is_ctrl)
            rdata = (pop_ok[fsel] && !empties[fsel]) ? heads[fsel] : '1;
        else if (addr[0])
            rdata = {{(DW-NF){1'b0}}, ovf};
        else
            rdata = {{(DW-CW){1'b0}}, depths[alloc_q]};
    end
endmodule

// File: rtl/msgq_pool.sv
// Module: pool of paired posted/free pointer lists shared by two buses.
// Assumes NF <= DW, MAX_DEPTH a power of two; local side has priority.
module msgq_pool #(
    parameter int DW        = 32,
    parameter int NUM_IN    = 2,
    parameter int NUM_OUT   = 2,
    parameter int MAX_DEPTH = 4,
    localparam int NQ       = NUM_IN + NUM_OUT,
    localparam int NF       = 2 * NQ,
    localparam int QW       = $clog2(NQ),
    localparam int BA       = QW + 2,
    localparam int PW       = $clog2(MAX_DEPTH),
    localparam int CW       = PW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lcl_vld,
    input  logic          lcl_we,
    input  logic [BA-1:0] lcl_addr,
    input  logic [DW-1:0] lcl_wdata,
    output logic [DW-1:0] lcl_rdata,
    input  logic          rmt_vld,
    input  logic          rmt_we,
    input  logic [BA-1:0] rmt_addr,
    input  logic [DW-1:0] rmt_wdata,
    output logic [DW-1:0] rmt_rdata,
    output logic          rmt_rdy,
    output logic [NF-1:0] lcl_ne,
    output logic [NF-1:0] rmt_ne
);
    logic [NF-1:0][DW-1:0] heads;
    logic [NF-1:0]         empties, drops, ovf;
    logic [NQ-1:0][CW-1:0] depths;
    logic [NF-1:0]         l_push, l_pop, l_ok, l_clr;
    logic [NF-1:0]         r_push, r_pop, r_ok, r_clr;
    logic                  l_alloc, r_alloc, clash, r_go;
    logic [QW-1:0]         l_aq, r_aq;

    // Remote waits when it collides with a local access.
    always_comb begin
        clash   = (lcl_addr[BA-2:1] == rmt_addr[BA-2:1])
                || (lcl_addr[BA-1] && rmt_addr[BA-1]);
        rmt_rdy = !(lcl_vld && rmt_vld && clash);
        r_go    = rmt_vld && rmt_rdy;
    end

    msgq_side #(.NQ(NQ), .NIN(NUM_IN), .DW(DW), .CW(CW), .IS_LOCAL(1'b1)) u_lcl (
        .go(lcl_vld), .we(lcl_we), .addr(lcl_addr), .wdata(lcl_wdata),
        .heads(heads), .empties(empties), .depths(depths), .ovf(ovf),
        .push(l_push), .pop(l_pop), .pop_ok(l_ok), .stat_clr(l_clr),
        .alloc_we(l_alloc), .alloc_q(l_aq), .rdata(lcl_rdata));

    msgq_side #(.NQ(NQ), .NIN(NUM_IN), .DW(DW), .CW(CW), .IS_LOCAL(1'b0)) u_rmt (
        .go(r_go), .we(rmt_we), .addr(rmt_addr), .wdata(rmt_wdata),
        .heads(heads), .empties(empties), .depths(depths), .ovf(ovf),
        .push(r_push), .pop(r_pop), .pop_ok(r_ok), .stat_clr(r_clr),
        .alloc_we(r_alloc), .alloc_q(r_aq), .rdata(rmt_rdata));

    // One FIFO per list; a list takes the data of the side pushing it.
    for (genvar f = 0; f < NF; f++) begin : g_list
        msgq_fifo #(.DW(DW), .DEPTH(MAX_DEPTH)) u_fifo (
            .clk(clk), .rst_n(rst_n),
            .push(l_push[f] || r_push[f]),
            .pop(l_pop[f] || r_pop[f]),
            .flush(l_alloc && (l_aq == QW'(f / 2))),
            .wdata(l_push[f] ? lcl_wdata : rmt_wdata),
            .limit(depths[f / 2]),
            .head(heads[f]), .empty(empties[f]), .drop(drops[f]));
    end

    // Run-time depth per queue, clamped to the storage size.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int q = 0; q < NQ; q++) depths[q] <= CW'(MAX_DEPTH);
        end else if (l_alloc) begin
            if (lcl_wdata[CW-1:0] == '0 || lcl_wdata[CW-1:0] > CW'(MAX_DEPTH))
                depths[l_aq] <= CW'(MAX_DEPTH);
            else
                depths[l_aq] <= lcl_wdata[CW-1:0];
        end
    end

    // Sticky drop status, set wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) ovf <= '0;
        else        ovf <= (ovf & ~(l_clr | r_clr)) | drops;
    end

    // Not-empty flags toward the popping side.
    always_comb begin
        lcl_ne = ~empties & l_ok;
        rmt_ne = ~empties & r_ok;
    end

    a_r9_no_shared_list: assert property (@(posedge clk) disable iff (!rst_n)
        ((l_push | l_pop) & (r_push | r_pop)) == '0);
    a_r8_ne_one_side: assert property (@(posedge clk) disable iff (!rst_n)
        (lcl_ne & rmt_ne) == '0);
    a_r4_sticky_kept: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(ovf) & ~$past(l_clr | r_clr) & ~ovf) == '0));
    a_r5_alloc_local_only: assert property (@(posedge clk) disable iff (!rst_n)
        !r_alloc);
endmodule

// File: tb/msgq_pool_tb.sv
module msgq_pool_tb;
    localparam int DW = 32;
    localparam int BA = 4;
    localparam int NF = 8;
    localparam logic [DW-1:0] SENT = 32'hFFFF_FFFF;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lcl_vld = 0, lcl_we = 0, rmt_vld = 0, rmt_we = 0;
    logic [BA-1:0] lcl_addr = '0, rmt_addr = '0;
    logic [DW-1:0] lcl_wdata = '0, rmt_wdata = '0;
    logic [DW-1:0] lcl_rdata, rmt_rdata;
    logic          rmt_rdy;
    logic [NF-1:0] lcl_ne, rmt_ne;

    int checks = 0, fails = 0;
    bit done = 0;
    logic [DW-1:0] exp_l[$], exp_r[$];
    string         tag_l[$], tag_r[$];

    always #5 clk = ~clk;

    msgq_pool #(.DW(DW), .NUM_IN(2), .NUM_OUT(2), .MAX_DEPTH(4)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .lcl_vld(lcl_vld), .lcl_we(lcl_we), .lcl_addr(lcl_addr),
        .lcl_wdata(lcl_wdata), .lcl_rdata(lcl_rdata),
        .rmt_vld(rmt_vld), .rmt_we(rmt_we), .rmt_addr(rmt_addr),
        .rmt_wdata(rmt_wdata), .rmt_rdata(rmt_rdata), .rmt_rdy(rmt_rdy),
        .lcl_ne(lcl_ne), .rmt_ne(rmt_ne));

    task automatic chk(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: compare read data against the scoreboard away from the edge.
    always @(negedge clk) begin
        if (lcl_vld && !lcl_we) begin
            if (exp_l.size() == 0) chk(lcl_rdata, 'x, "local read unexpected");
            else chk(lcl_rdata, exp_l.pop_front(), tag_l.pop_front());
        end
        if (rmt_vld && !rmt_we && rmt_rdy) begin
            if (exp_r.size() == 0) chk(rmt_rdata, 'x, "remote read unexpected");
            else chk(rmt_rdata, exp_r.pop_front(), tag_r.pop_front());
        end
    end

    task automatic lacc(input logic we, input logic [BA-1:0] a, input logic [DW-1:0] d);
        @(posedge clk); #1;
        lcl_vld = 1; lcl_we = we; lcl_addr = a; lcl_wdata = d;
        @(posedge clk); #1;
        lcl_vld = 0;
    endtask

    task automatic racc(input logic we, input logic [BA-1:0] a, input logic [DW-1:0] d);
        @(posedge clk); #1;
        rmt_vld = 1; rmt_we = we; rmt_addr = a; rmt_wdata = d;
        @(posedge clk); #1;
        rmt_vld = 0;
    endtask

    task automatic lwr(input logic [BA-1:0] a, input logic [DW-1:0] d);
        lacc(1'b1, a, d);
    endtask
    task automatic rwr(input logic [BA-1:0] a, input logic [DW-1:0] d);
        racc(1'b1, a, d);
    endtask
    task automatic lrd(input logic [BA-1:0] a, input logic [DW-1:0] e, input string t);
        exp_l.push_back(e); tag_l.push_back(t);
        lacc(1'b0, a, '0);
    endtask
    task automatic rrd(input logic [BA-1:0] a, input logic [DW-1:0] e, input string t);
        exp_r.push_back(e); tag_r.push_back(t);
        racc(1'b0, a, '0);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R7 reset state
        chk(DW'(lcl_ne), 0, "R7 lcl_ne after reset");
        chk(DW'(rmt_ne), 0, "R7 rmt_ne after reset");
        lrd(4'h8, 4, "R7 depth at reset");
        lrd(4'h9, 0, "R7 status at reset");
        // R3 empty pop
        lrd(4'h0, SENT, "R3 empty pop");
        chk(DW'(lcl_ne), 0, "R3 still empty");
        // R10/R8 frame cycle on inbound queue 0
        lwr(4'h1, 32'h100);
        lwr(4'h1, 32'h200);
        chk(DW'(rmt_ne), 32'h2, "R8 remote ne free list");
        rrd(4'h1, 32'h100, "R2 remote takes free pointer");
        rwr(4'h0, 32'h100);
        chk(DW'(lcl_ne), 32'h1, "R8 local ne posted list");
        chk(DW'(rmt_ne), 32'h2, "R10 free list untouched by post");
        lrd(4'h0, 32'h100, "R10 local pops posted pointer");
        rrd(4'h1, 32'h200, "R2 next free pointer");
        rrd(4'h1, SENT, "R3 free list drained");
        // R5 wrong-side access
        rwr(4'h0, 32'h55);
        rrd(4'h0, SENT, "R5 remote pop of inbound post rejected");
        lwr(4'h0, 32'hBAD);
        lrd(4'h0, 32'h55, "R5 entry kept, wrong-side push dropped");
        lrd(4'h0, SENT, "R5 nothing extra queued");
        lrd(4'h9, 0, "R5 no status from wrong side");
        // R1/R4 order and full
        for (int i = 1; i <= 5; i++) rwr(4'h0, DW'(i));
        lrd(4'h9, 32'h1, "R4 drop bit set");
        for (int i = 1; i <= 4; i++) lrd(4'h0, DW'(i), "R1 fifo order");
        lrd(4'h0, SENT, "R4 fifth push dropped");
        lrd(4'h9, 32'h1, "R4 bit sticky");
        rwr(4'h9, 32'h1);
        lrd(4'h9, 0, "R4 bit cleared");
        // R5 outbound queue 2
        lwr(4'h4, 32'hA0);
        chk(DW'(rmt_ne), 32'h10, "R8 remote ne outbound post");
        lrd(4'h4, SENT, "R5 local pop of outbound post rejected");
        rrd(4'h4, 32'hA0, "R5 remote pops outbound");
        // R6 allocation
        lwr(4'hC, 2);
        rrd(4'hC, 2, "R6 depth readback");
        lwr(4'h4, 32'hB1);
        lwr(4'h4, 32'hB2);
        lwr(4'h4, 32'hB3);
        lrd(4'h9, 32'h10, "R6 depth two drops third");
        rrd(4'h4, 32'hB1, "R6 first");
        rrd(4'h4, 32'hB2, "R6 second");
        rrd(4'h4, SENT, "R6 third dropped");
        lwr(4'h4, 32'hE1);
        lwr(4'hC, 2);
        chk(DW'(rmt_ne), 0, "R6 flush clears ne");
        rrd(4'h4, SENT, "R6 flush empties list");
        rwr(4'hC, 3);
        lrd(4'hC, 2, "R6 remote alloc ignored");
        lwr(4'hC, 0);
        lrd(4'hC, 4, "R6 zero selects max");
        // R9 collision on queue 0
        @(posedge clk); #1;
        exp_l.push_back(SENT); tag_l.push_back("R9 local read wins");
        lcl_vld = 1; lcl_we = 0; lcl_addr = 4'h0;
        rmt_vld = 1; rmt_we = 1; rmt_addr = 4'h0; rmt_wdata = 32'h77;
        @(negedge clk);
        chk(DW'(rmt_rdy), 0, "R9 remote stalled");
        @(posedge clk); #1;
        lcl_vld = 0;
        @(negedge clk);
        chk(DW'(rmt_rdy), 1, "R9 remote accepted later");
        @(posedge clk); #1;
        rmt_vld = 0;
        lrd(4'h0, 32'h77, "R9 remote push completed");
        repeat (3) @(posedge clk);
        chk(DW'(exp_l.size() + exp_r.size()), 0, "all reads observed");
        done = 1;
        summary();
        $finish;
    end
endmodule